// File: doc/BRIEF.md
# ISA 16-bit Target Address Front-End

This block sits at the bus edge of a 16-bit ISA expansion card that answers as a bus target. The seven high address lines of the 16-bit connector arrive half a clock before the rest of the address, but they are not guaranteed to stay valid for the whole cycle. The block decodes those early lines at once. When they fall inside the card's window, it asks the host for a 16-bit transfer. It also holds the early lines under the address latch enable strobe, so that the decode stays valid while the data phase runs.

The held high bits are joined with the system address bits that lie just below them. Together they are compared against a programmable base to give a card select that stays stable through the data phase. The read and write strobes reach the card core only while that select is true and no DMA cycle is flagged. The 16-bit request pin is open-drain: it is modelled as an output enable plus a value that is always low.

The address is split into 7 early bits (bits 23..17 of the full address) and 17 system bits (16..0). The card window is 16 KB, set by bits 13..0. The base therefore names address bits 23..14. Base bits [9:3] are compared with the high bits, and base bits [2:0] are compared with system address bits 16..14.

Top module: `isa_tgt_front`

## Requirements
- R1: While `ale` is 1, the effective high bits equal `early_hi` in the same cycle, with no clock delay. `io16_oe` follows `early_hi` combinationally.
- R2: When `ale` is 0, the effective high bits are the value of `early_hi` sampled at the last rising clock edge at which `ale` was 1. Changes on `early_hi` while `ale` is 0 have no effect on `io16_oe` or `card_sel`.
- R3: `io16_oe` is 1 exactly when the effective high bits equal `cfg_base[9:3]`. `io16_val` is always 0. The system address bits do not influence `io16_oe`.
- R4: `card_sel` is 1 exactly when two conditions hold: the effective high bits equal `cfg_base[9:3]`, and `sys_addr_hi` (address bits 16..14) equals `cfg_base[2:0]`.
- R5: `core_rd` is 1 exactly when `rd_n` is 0, `card_sel` is 1 and `dma_cyc` is 0.
- R6: `core_wr` is 1 exactly when `wr_n` is 0, `card_sel` is 1 and `dma_cyc` is 0.
- R7: While `dma_cyc` is 1, `core_rd` and `core_wr` are both 0, whatever the strobes and the address.
- R8: An active-low `rst_n` clears the held high bits to zero. With `ale` low after reset, the effective high bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch enable; the hold is transparent while high |
| early_hi | input | 7 | Unlatched early address bits 23..17 |
| sys_addr_hi | input | 3 | System address bits 16..14 |
| cfg_base | input | 10 | Card base, address bits 23..14 |
| rd_n | input | 1 | Bus read strobe, active low |
| wr_n | input | 1 | Bus write strobe, active low |
| dma_cyc | input | 1 | High while a DMA cycle owns the bus |
| io16_oe | output | 1 | Drive enable of the 16-bit request pin |
| io16_val | output | 1 | Level driven when enabled (always 0) |
| card_sel | output | 1 | Stable card select for the data phase |
| core_rd | output | 1 | Qualified read strobe to the card core |
| core_wr | output | 1 | Qualified write strobe to the card core |

## Verification
The clocked properties assume that `ale`, `early_hi` and `dma_cyc` change only between rising clock edges. The stimulus drives every input on the falling edge to meet that. The properties on the hold register also assume that reset is applied from the first edge.

The bench biases `early_hi` and `sys_addr_hi` toward the base so that matches and near-misses both occur often. It then moves `early_hi` freely while `ale` is low, to show that the held value alone drives the decode.

// File: rtl/isa_tgt_pkg.sv
package isa_tgt_pkg;
  parameter int HI_W   = 7;   // early high address bits
  parameter int LO_W   = 17;  // system address bits below them
  parameter int WIN_W  = 14;  // log2 of the card window
  localparam int SEL_W  = LO_W - WIN_W;   // system bits used by decode
  localparam int BASE_W = HI_W + SEL_W;   // base covers bits above window

  function automatic logic hi_hit(input logic [HI_W-1:0] hi,
                                  input logic [BASE_W-1:0] base);
    return hi == base[BASE_W-1 -: HI_W];
  endfunction

  function automatic logic lo_hit(input logic [SEL_W-1:0] lo,
                                  input logic [BASE_W-1:0] base);
    return lo == base[SEL_W-1:0];
  endfunction
endpackage

// File: rtl/isa_hi_hold.sv
module isa_hi_hold
  import isa_tgt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [HI_W-1:0] early_hi,
  output logic [HI_W-1:0] eff_hi
);
  logic [HI_W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held_q <= '0;
    else if (ale) held_q <= early_hi;
  end

  // transparent while ale is high, held value otherwise
  assign eff_hi = ale ? early_hi : held_q;

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (held_q == $past(early_hi)));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(held_q));
endmodule

// File: rtl/isa_addr_dec.sv
module isa_addr_dec
  import isa_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HI_W-1:0]   eff_hi,
  input  logic [SEL_W-1:0]  sys_addr_hi,
  input  logic [BASE_W-1:0] cfg_base,
  output logic              hi_match,
  output logic              sel
);
  assign hi_match = hi_hit(eff_hi, cfg_base);
  assign sel      = hi_match && lo_hit(sys_addr_hi, cfg_base);

  p_sel_needs_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> hi_match);
endmodule

// File: rtl/isa_strobe_qual.sv
module isa_strobe_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic dma_cyc,
  input  logic rd_n,
  input  logic wr_n,
  output logic core_rd,
  output logic core_wr
);
  logic pass;
  assign pass    = sel && !dma_cyc;
  assign core_rd = pass && !rd_n;
  assign core_wr = pass && !wr_n;

  p_dma_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_cyc |-> (!core_rd && !core_wr));
  p_rd_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_rd |-> (sel && !rd_n));
  p_wr_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr |-> (sel && !wr_n));
endmodule

// File: rtl/isa_tgt_front.sv
module isa_tgt_front
  import isa_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [HI_W-1:0]   early_hi,
  input  logic [SEL_W-1:0]  sys_addr_hi,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              dma_cyc,
  output logic              io16_oe,
  output logic              io16_val,
  output logic              card_sel,
  output logic              core_rd,
  output logic              core_wr
);
  logic [HI_W-1:0] eff_hi;
  logic            hi_match;

  isa_hi_hold u_hold (
    .clk(clk), .rst_n(rst_n), .ale(ale), .early_hi(early_hi), .eff_hi(eff_hi)
  );

  isa_addr_dec u_dec (
    .clk(clk), .rst_n(rst_n), .eff_hi(eff_hi), .sys_addr_hi(sys_addr_hi),
    .cfg_base(cfg_base), .hi_match(hi_match), .sel(card_sel)
  );

  isa_strobe_qual u_qual (
    .clk(clk), .rst_n(rst_n), .sel(card_sel), .dma_cyc(dma_cyc),
    .rd_n(rd_n), .wr_n(wr_n), .core_rd(core_rd), .core_wr(core_wr)
  );

  // open-drain request: enable from the early-bit decode, level always low
  assign io16_oe  = hi_match;
  assign io16_val = 1'b0;

  p_sel_io16_r3: assert property (@(posedge clk) disable iff (!rst_n)
    card_sel |-> io16_oe);
  p_transparent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && (early_hi == cfg_base[BASE_W-1 -: HI_W])) |-> io16_oe);
endmodule

// File: tb/sim_isa_tgt_front.sv
module sim_isa_tgt_front;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0;
  logic [6:0] early_hi = '0;
  logic [2:0] sys_addr_hi = '0;
  logic [9:0] cfg_base = 10'h2A5;
  logic       rd_n = 1'b1, wr_n = 1'b1, dma_cyc = 1'b0;
  logic       io16_oe, io16_val, card_sel, core_rd, core_wr;

  int checks = 0, failures = 0;
  int held = 0;          // model of the held high bits
  string phase = "R3";
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  isa_tgt_front u0 (.*);

  // reference model: held bits follow early lines on edges with ale high
  always @(posedge clk or negedge rst_n)
    if (!rst_n) held <= 0;
    else if (ale) held <= int'(early_hi);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int hi, hm, sel, pass;
    hi   = ale ? int'(early_hi) : held;
    hm   = (hi == int'(cfg_base) / 8) ? 1 : 0;
    sel  = (hm == 1 && int'(sys_addr_hi) == int'(cfg_base) % 8) ? 1 : 0;
    pass = (sel == 1 && dma_cyc == 1'b0) ? 1 : 0;
    chk({phase, " io16_oe R3"}, int'(io16_oe), hm);
    chk("R3 io16_val", int'(io16_val), 0);
    chk({phase, " card_sel R4"}, int'(card_sel), sel);
    chk("R5 core_rd", int'(core_rd), (pass == 1 && rd_n == 1'b0) ? 1 : 0);
    chk("R6 core_wr", int'(core_wr), (pass == 1 && wr_n == 1'b0) ? 1 : 0);
    if (dma_cyc) chk("R7 dma block", int'(core_rd | core_wr), 0);
  endtask

  // drive on falling edge, check mid-low phase
  task automatic step(input bit a, input logic [6:0] h, input logic [2:0] s,
                      input bit r, input bit w, input bit d);
    @(negedge clk);
    ale = a; early_hi = h; sys_addr_hi = s; rd_n = r; wr_n = w; dma_cyc = d;
    #5 compare_all();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [6:0] bh;
    logic [2:0] bl;
    bh = cfg_base[9:3]; bl = cfg_base[2:0];
    // R8: reset clears the held bits; early lines ignored while ale low
    repeat (2) @(negedge clk);
    early_hi = bh; sys_addr_hi = bl;
    #5 phase = "R8"; compare_all();
    chk("R8 reset sel", int'(card_sel), 0);
    @(negedge clk); rst_n = 1'b1;
    step(0, bh, bl, 0, 1, 0);
    chk("R8 after reset", int'(io16_oe), 0);
    // R1: transparent with ale high, same cycle
    phase = "R1";
    step(1, bh, bl, 1, 1, 0);
    chk("R1 follow", int'(io16_oe), 1);
    step(1, bh ^ 7'h01, bl, 1, 1, 0);
    chk("R1 follow miss", int'(io16_oe), 0);
    step(1, bh, bl, 1, 1, 0);
    // R2: ale falls, early lines wander, decode holds
    phase = "R2";
    step(0, 7'h00, bl, 0, 1, 0);
    chk("R2 hold sel", int'(card_sel), 1);
    chk("R2 hold rd", int'(core_rd), 1);
    step(0, ~bh, bl, 1, 0, 0);
    chk("R2 hold wr", int'(core_wr), 1);
    step(0, ~bh, bl ^ 3'b100, 1, 0, 0);
    chk("R4 low miss", int'(card_sel), 0);
    chk("R3 io16 ignores sys addr", int'(io16_oe), 1);
    // R7: DMA blocks strobes even when selected
    phase = "R7";
    step(0, 7'h11, bl, 0, 0, 1);
    chk("R7 both blocked", int'(core_rd | core_wr), 0);
    // held miss, then capture with ale high and hold
    step(1, bh ^ 7'h40, bl, 0, 1, 0);
    step(0, bh, bl, 0, 1, 0);
    chk("R2 held miss", int'(card_sel), 0);
    // random traffic biased to the base
    phase = "RND";
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] h;
      logic [2:0] s;
      h = ($urandom % 2) ? bh : 7'($urandom);
      s = ($urandom % 2) ? bl : 3'($urandom);
      if (i == 1500) cfg_base = 10'h05E;
      bh = cfg_base[9:3]; bl = cfg_base[2:0];
      step(($urandom % 3) == 0, h, s, $urandom % 2 == 1, $urandom % 2 == 1,
           ($urandom % 5) == 0);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule